// File: doc/BRIEF.md
# Odd/even descrambling key bank

This block keeps the keys that a transport stream descrambler needs and hands the correct one out for every incoming packet. It sits on the input stream ahead of demultiplexing. It holds a fixed number of indexed entries, and each entry carries two 64-bit control words, one even and one odd. It also holds one separate fallback word for packets whose stream has no dedicated entry.

A CPU loads keys through a simple write port, 32 bits at a time. The low half of a word is only parked in a staging register. The whole 64-bit word is written into the bank when the high half arrives, so a lookup never returns a key that is half old and half new.

The packet side presents a lookup request with a key index, a "no entry" flag and the packet's two-bit scrambling-control field. One clock later the block returns a 64-bit control word and a flag that tells the cipher whether to descramble the packet.

Top module: `keybank_top`

## Requirements
- R1: After reset every stored word, the fallback word and the staging register are zero, and lk_valid, lk_en and lk_cw are all low.
- R2: lk_valid is high in exactly the cycles that follow a cycle with lk_req high, so each result appears one clock after its request.
- R3: For lk_idx below NUM_SLOTS with lk_noentry low, a scrambling-control value of 2'b10 returns that entry's even word and 2'b11 returns its odd word, with lk_en high.
- R4: A scrambling-control value of 2'b00 (clear) or 2'b01 (reserved) returns lk_en low and lk_cw zero, whatever the index.
- R5: When lk_noentry is high or lk_idx is NUM_SLOTS or more, a scrambling-control value of 2'b10 or 2'b11 returns the fallback word with lk_en high.
- R6: A write with wr_hi low stores wr_data in the staging register. A write with wr_hi high commits {wr_data, staging} as bits 63:32 and 31:0. The target is the odd word of entry wr_slot when wr_odd is 1 and the even word when wr_odd is 0. If wr_slot is NUM_SLOTS or more, the target is the fallback word and wr_odd is ignored.
- R7: A low-half write on its own leaves every stored word unchanged.
- R8: A lookup requested in the same cycle as a commit returns the value held before the commit. A lookup requested in the next cycle returns the new value.
- R9: In a cycle that follows no request, lk_en is low and lk_cw is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_hi | input | 1 | 1: high half (commit), 0: low half (stage) |
| wr_odd | input | 1 | 1: odd word, 0: even word |
| wr_slot | input | 4 | Entry index; NUM_SLOTS or more selects the fallback word |
| wr_data | input | 32 | Half-word data |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 4 | Key index of the packet |
| lk_noentry | input | 1 | Packet has no dedicated entry |
| lk_scv | input | 2 | Scrambling-control field of the packet |
| lk_valid | output | 1 | Result valid, one cycle after lk_req |
| lk_en | output | 1 | Descramble this packet |
| lk_cw | output | 64 | Selected control word |

## Verification
The bench aims at the cases where a key changes under an active stream. These are a staged low half followed by lookups, which would show a torn word if the bank were written early. They also include a lookup issued in the very cycle of a commit, which would return the new key one packet too soon if the bank read through its write. The bench also probes indexes 14 and 15 and the "no entry" flag, where a decoder that wrapped the index would return an indexed pair instead of the fallback. It probes the reserved code 01, which a design that decoded only bit 0 would treat as odd. Random traffic then mixes writes to all targets with lookups of every code.

// File: rtl/keybank_pkg.sv
package keybank_pkg;
    // scrambling-control codes carried by each packet
    typedef enum logic [1:0] {
        SC_CLEAR = 2'b00,
        SC_RSVD  = 2'b01,
        SC_EVEN  = 2'b10,
        SC_ODD   = 2'b11
    } scv_e;

    function automatic logic scv_keyed(input logic [1:0] scv);
        return (scv == SC_EVEN) || (scv == SC_ODD);
    endfunction
endpackage

// File: rtl/kb_store.sv
module kb_store #(
    parameter int NUM_SLOTS = 14,
    parameter int HALF_W    = 32,
    localparam int CW_W     = 2 * HALF_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_hi,
    input  logic                             wr_odd,
    input  logic [IDX_W-1:0]                 wr_slot,
    input  logic [HALF_W-1:0]                wr_data,
    output logic [NUM_SLOTS-1:0][CW_W-1:0]   even_words,
    output logic [NUM_SLOTS-1:0][CW_W-1:0]   odd_words,
    output logic [CW_W-1:0]                  dflt_word
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][CW_W-1:0] ev;
        logic [NUM_SLOTS-1:0][CW_W-1:0] od;
        logic [CW_W-1:0]                df;
        logic [HALF_W-1:0]              lo;
    } store_t;

    store_t st_d, st_q;
    logic [CW_W-1:0] commit_word;
    logic            to_dflt;

    always_comb begin
        st_d        = st_q;
        commit_word = {wr_data, st_q.lo};
        to_dflt     = (wr_slot >= IDX_W'(NUM_SLOTS));
        if (wr_en) begin
            if (!wr_hi) begin
                st_d.lo = wr_data;
            end else if (to_dflt) begin
                st_d.df = commit_word;
            end else begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (wr_slot == IDX_W'(i)) begin
                        if (wr_odd) st_d.od[i] = commit_word;
                        else        st_d.ev[i] = commit_word;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign even_words = st_q.ev;
    assign odd_words  = st_q.od;
    assign dflt_word  = st_q.df;
endmodule

// File: rtl/kb_select.sv
module kb_select
    import keybank_pkg::*;
#(
    parameter int NUM_SLOTS = 14,
    parameter int CW_W      = 64,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             lk_req,
    input  logic [IDX_W-1:0]                 lk_idx,
    input  logic                             lk_noentry,
    input  logic [1:0]                       lk_scv,
    input  logic [NUM_SLOTS-1:0][CW_W-1:0]   even_words,
    input  logic [NUM_SLOTS-1:0][CW_W-1:0]   odd_words,
    input  logic [CW_W-1:0]                  dflt_word,
    output logic                             lk_valid,
    output logic                             lk_en,
    output logic [CW_W-1:0]                  lk_cw
);
    typedef struct packed {
        logic            valid;
        logic            en;
        logic [CW_W-1:0] cw;
    } res_t;

    res_t res_d, res_q;
    logic [CW_W-1:0] pair_ev, pair_od, picked;
    logic            use_dflt;

    always_comb begin
        pair_ev = '0;
        pair_od = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (lk_idx == IDX_W'(i)) begin
                pair_ev = even_words[i];
                pair_od = odd_words[i];
            end
        end
        use_dflt = lk_noentry || (lk_idx >= IDX_W'(NUM_SLOTS));
        if (use_dflt)                  picked = dflt_word;
        else if (lk_scv == SC_ODD)     picked = pair_od;
        else                           picked = pair_ev;

        res_d       = '0;
        res_d.valid = lk_req;
        if (lk_req && scv_keyed(lk_scv)) begin
            res_d.en = 1'b1;
            res_d.cw = picked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign lk_valid = res_q.valid;
    assign lk_en    = res_q.en;
    assign lk_cw    = res_q.cw;
endmodule

// File: rtl/keybank_top.sv
module keybank_top #(
    parameter int NUM_SLOTS = 14,
    parameter int HALF_W    = 32,
    localparam int CW_W     = 2 * HALF_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic              wr_odd,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              lk_req,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_noentry,
    input  logic [1:0]        lk_scv,
    output logic              lk_valid,
    output logic              lk_en,
    output logic [CW_W-1:0]   lk_cw
);
    logic [NUM_SLOTS-1:0][CW_W-1:0] even_words;
    logic [NUM_SLOTS-1:0][CW_W-1:0] odd_words;
    logic [CW_W-1:0]                dflt_word;

    kb_store #(.NUM_SLOTS(NUM_SLOTS), .HALF_W(HALF_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_hi      (wr_hi),
        .wr_odd     (wr_odd),
        .wr_slot    (wr_slot),
        .wr_data    (wr_data),
        .even_words (even_words),
        .odd_words  (odd_words),
        .dflt_word  (dflt_word)
    );

    kb_select #(.NUM_SLOTS(NUM_SLOTS), .CW_W(CW_W)) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_req     (lk_req),
        .lk_idx     (lk_idx),
        .lk_noentry (lk_noentry),
        .lk_scv     (lk_scv),
        .even_words (even_words),
        .odd_words  (odd_words),
        .dflt_word  (dflt_word),
        .lk_valid   (lk_valid),
        .lk_en      (lk_en),
        .lk_cw      (lk_cw)
    );
endmodule

// File: rtl/kb_chk.sv
module kb_chk #(
    parameter int CW_W  = 64,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [1:0]       lk_scv,
    input logic             lk_valid,
    input logic             lk_en,
    input logic [CW_W-1:0]  lk_cw
);
    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);
    // R4
    clear_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_scv[1]) |=> (!lk_en && lk_cw == '0));
    // R3
    keyed_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_scv[1]) |=> lk_en);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_en && lk_cw == '0));
endmodule

bind keybank_top kb_chk #(.CW_W(CW_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_scv   (lk_scv),
    .lk_valid (lk_valid),
    .lk_en    (lk_en),
    .lk_cw    (lk_cw)
);

// File: tb/sim_keybank_top.sv
module sim_keybank_top;
    localparam int PERIOD = 10;
    localparam int NS = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_hi = 1'b0, wr_odd = 1'b0;
    logic [3:0]  wr_slot = '0;
    logic [31:0] wr_data = '0;
    logic        lk_req = 1'b0, lk_noentry = 1'b0;
    logic [3:0]  lk_idx = '0;
    logic [1:0]  lk_scv = '0;
    logic        lk_valid, lk_en;
    logic [63:0] lk_cw;

    int total = 0;
    int bad = 0;

    logic [63:0] ev_m [NS];
    logic [63:0] od_m [NS];
    logic [63:0] df_m;
    logic [31:0] lo_m;

    always #(PERIOD/2) clk = ~clk;

    keybank_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_odd(wr_odd),
        .wr_slot(wr_slot), .wr_data(wr_data), .lk_req(lk_req), .lk_idx(lk_idx),
        .lk_noentry(lk_noentry), .lk_scv(lk_scv), .lk_valid(lk_valid),
        .lk_en(lk_en), .lk_cw(lk_cw)
    );

    function automatic logic [64:0] expect_fn(logic [3:0] ix, logic ne, logic [1:0] sc);
        if (!sc[1]) return '0;
        if (ne || ix >= 4'(NS)) return {1'b1, df_m};
        return sc[0] ? {1'b1, od_m[ix]} : {1'b1, ev_m[ix]};
    endfunction

    task automatic check(string tag, logic v, logic e, logic [63:0] cw);
        total++;
        if (lk_valid !== v || lk_en !== e || lk_cw !== cw) begin
            bad++;
            $display("FAIL %s: got valid=%0b en=%0b cw=%h expected valid=%0b en=%0b cw=%h",
                     tag, lk_valid, lk_en, lk_cw, v, e, cw);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(bit we, bit hi, bit odd, logic [3:0] slot, logic [31:0] d,
                        bit rq, logic [3:0] ix, bit ne, logic [1:0] sc, string tag);
        logic [64:0] ex;
        wr_en = we; wr_hi = hi; wr_odd = odd; wr_slot = slot; wr_data = d;
        lk_req = rq; lk_idx = ix; lk_noentry = ne; lk_scv = sc;
        ex = rq ? expect_fn(ix, ne, sc) : 65'd0;
        @(posedge clk);
        if (we) begin
            if (!hi) lo_m = d;
            else if (slot >= 4'(NS)) df_m = {d, lo_m};
            else if (odd) od_m[slot] = {d, lo_m};
            else ev_m[slot] = {d, lo_m};
        end
        @(negedge clk);
        check(tag, rq, ex[64], ex[63:0]);
    endtask

    task automatic wr64(logic [3:0] slot, bit odd, logic [63:0] w);
        step(1, 0, odd, slot, w[31:0], 0, 0, 0, 0, "R9 idle during write");
        step(1, 1, odd, slot, w[63:32], 0, 0, 0, 0, "R9 idle during write");
    endtask

    initial begin
        #(PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        for (int i = 0; i < NS; i++) begin ev_m[i] = '0; od_m[i] = '0; end
        df_m = '0; lo_m = '0;
        repeat (3) @(negedge clk);
        // R1 reset state at outputs
        check("R1 reset outputs", 0, 0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 stored words zero after reset
        step(0, 0, 0, 0, 0, 1, 4'd3, 0, 2'b10, "R1 reset even word");
        step(0, 0, 0, 0, 0, 1, 4'd15, 0, 2'b11, "R1 reset fallback word");

        // R6 directed loads
        wr64(4'd0, 0, 64'h0123_4567_89ab_cdef);
        wr64(4'd0, 1, 64'hfedc_ba98_7654_3210);
        wr64(4'd13, 1, 64'h1313_1313_abab_abab);
        wr64(4'd14, 1, 64'hdead_beef_cafe_f00d);
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b10, "R3 R6 even word entry 0");
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b11, "R3 R6 odd word entry 0");
        step(0, 0, 0, 0, 0, 1, 4'd13, 0, 2'b11, "R3 R6 odd word last entry");
        step(0, 0, 0, 0, 0, 1, 4'd14, 0, 2'b10, "R5 index 14 fallback");
        step(0, 0, 0, 0, 0, 1, 4'd15, 0, 2'b11, "R5 index 15 fallback");
        step(0, 0, 0, 0, 0, 1, 4'd0, 1, 2'b10, "R5 noentry fallback");
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b00, "R4 clear code");
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b01, "R4 reserved code");
        step(0, 0, 0, 0, 0, 0, 4'd0, 0, 2'b11, "R9 no request");

        // R7 low half alone changes nothing
        step(1, 0, 0, 4'd0, 32'h5555_aaaa, 0, 0, 0, 0, "R7 stage only");
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b10, "R7 even word untouched");
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b11, "R7 odd word untouched");
        // R8 commit and lookup in the same cycle, then next cycle
        step(1, 1, 0, 4'd0, 32'h7777_1111, 1, 4'd0, 0, 2'b10, "R8 same-cycle old value");
        step(0, 0, 0, 0, 0, 1, 4'd0, 0, 2'b10, "R8 next-cycle new value");
        // R6 fallback target ignores parity
        wr64(4'd15, 0, 64'h0f0f_0f0f_f0f0_f0f0);
        step(0, 0, 0, 0, 0, 1, 4'd2, 1, 2'b11, "R6 fallback written via slot 15");

        // R2 back-to-back requests, then random mix
        for (int n = 0; n < 4000; n++) begin
            bit we, hi, odd, rq, ne;
            logic [3:0] slot, ix;
            logic [1:0] sc;
            string tag;
            we = ($urandom % 3) == 0;
            hi = $urandom % 2;
            odd = $urandom % 2;
            slot = 4'($urandom % 16);
            rq = ($urandom % 4) != 0;
            ix = 4'($urandom % 16);
            ne = ($urandom % 8) == 0;
            sc = 2'($urandom % 4);
            if (!rq) tag = "R2 R9 random idle";
            else if (!sc[1]) tag = "R4 random clear";
            else if (ne || ix >= 4'(NS)) tag = "R5 random fallback";
            else tag = "R3 R6 random keyed";
            step(we, hi, odd, slot, $urandom, rq, ix, ne, sc, tag);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule